// File: doc/BRIEF.md
# AHB-Lite Bus Rule Monitor

A passive, synthesizable watcher for one AHB-Lite port. It samples the address, control, ready and response signals on every rising clock edge and never drives anything back onto the bus. Each protocol rule it knows has its own violation flag. A flag rises from the clock edge that samples the offending cycle and stays high until reset.

Beside the flags, three counters record how often the situations that arm the checks actually happened: wait cycles, completed error responses and finished fixed-length bursts. A run that shows clean flags but zero counts has therefore proved nothing, and the counts make that visible. The monitor is meant to be left in silicon or emulation next to a port, or attached to a bus model during simulation.

Top module: `ahbl_watch`

## Requirements
- R1: When a sampled cycle has `bus_ready` low, the next sampled cycle must repeat `bus_addr`, `bus_write`, `bus_size` and `bus_burst`. If any of them differs, `flag_hold` is set at the edge that samples that next cycle.
- R2: `flag_stall` is set at the edge that samples the MAXW-th consecutive cycle with `bus_ready` low. A run of MAXW-1 low cycles followed by a high cycle leaves it clear, and any high cycle restarts the run.
- R3: Response codes are 2'b00 OK and 2'b01 ERROR. After a cycle showing ERROR with `bus_ready` low, the next cycle must show ERROR with `bus_ready` high. Any other combination sets `flag_err_seq`.
- R4: A sampled `bus_resp` of 2'b10 or 2'b11 sets `flag_resp_code`.
- R5: `bus_burst` uses 0 single, 1 open-length increment, 2/4/6 wrap of 4/8/16 beats, and 3/5/7 increment of 4/8/16 beats. Inside a burst, every SEQ (2'b11) address must equal the previous accepted beat's address plus 2^`bus_size`. For wrapping bursts the sum wraps inside an aligned block of beats×2^`bus_size` bytes. A mismatch sets `flag_burst_addr`.
- R6: Transfer codes are IDLE 2'b00, BUSY 2'b01, NONSEQ 2'b10 and SEQ 2'b11. A beat is accepted when `bus_ready` is high and the code is NONSEQ or SEQ. A burst starts with an accepted NONSEQ whose `bus_burst` is not 0. While a fixed-length burst still has beats left, IDLE or NONSEQ sets `flag_burst_type`. An open-length burst ends on IDLE or NONSEQ with no flag.
- R7: Reset clears every flag and counter. All flags are sticky until the next reset.
- R8: `any_violation` is high exactly when at least one flag is high.
- R9: `cov_wait` counts sampled cycles with `bus_ready` low.
- R10: `cov_err` counts sampled cycles with ERROR and `bus_ready` high.
- R11: `cov_burst` counts fixed-length bursts whose final beat has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Transfer address |
| bus_trans | input | 2 | Transfer type code |
| bus_write | input | 1 | Write direction |
| bus_size | input | 3 | log2 of transfer bytes |
| bus_burst | input | 3 | Burst kind code |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_resp | input | 2 | Response code |
| flag_hold | output | 1 | Control changed during a wait |
| flag_stall | output | 1 | Ready held low too long |
| flag_err_seq | output | 1 | Error response not two cycles |
| flag_resp_code | output | 1 | Illegal response code seen |
| flag_burst_addr | output | 1 | Wrong burst beat address |
| flag_burst_type | output | 1 | Illegal transfer type mid-burst |
| any_violation | output | 1 | OR of all flags |
| cov_wait | output | CW | Wait cycle count |
| cov_err | output | CW | Completed error count |
| cov_burst | output | CW | Completed fixed burst count |

## Verification
A long seeded stream of legal traffic is applied first. It mixes singles with two-cycle errors, every burst kind, inserted BUSY cycles and short waits, and it must leave every flag clear while the counters match the bench's own tallies. This separates a monitor that over-reports from one that is merely quiet. Each rule is then broken on its own after a fresh reset, and exactly one matching flag must rise. That shows which rule fired, not just that something fired. Boundary patterns then pin the exact limits: a stall one cycle short of the bound against one that reaches it, a wrapping burst that crosses its block edge, and an open-length burst ended by IDLE.

// File: rtl/ahbl_watch.sv
module ahbl_watch #(
  parameter int AW   = 32,
  parameter int MAXW = 16,
  parameter int CW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_trans,
  input  logic          bus_write,
  input  logic [2:0]    bus_size,
  input  logic [2:0]    bus_burst,
  input  logic          bus_ready,
  input  logic [1:0]    bus_resp,
  output logic          flag_hold,
  output logic          flag_stall,
  output logic          flag_err_seq,
  output logic          flag_resp_code,
  output logic          flag_burst_addr,
  output logic          flag_burst_type,
  output logic          any_violation,
  output logic [CW-1:0] cov_wait,
  output logic [CW-1:0] cov_err,
  output logic [CW-1:0] cov_burst
);

  localparam int LW = $clog2(MAXW + 1);
  localparam logic [1:0] T_IDLE = 2'b00;
  localparam logic [1:0] T_NSEQ = 2'b10;
  localparam logic [1:0] T_SEQ  = 2'b11;
  localparam logic [1:0] R_ERR  = 2'b01;

  function automatic logic [4:0] beats_of(input logic [2:0] k);
    case (k)
      3'd2, 3'd3: return 5'd4;
      3'd4, 3'd5: return 5'd8;
      3'd6, 3'd7: return 5'd16;
      default:    return 5'd0;
    endcase
  endfunction

  // previous-cycle view
  logic [AW-1:0] p_addr;
  logic          p_write;
  logic [2:0]    p_size, p_burst;
  logic          p_ready, p_err1;
  logic [LW-1:0] lcnt;

  // burst tracker
  logic          in_bst, bst_fix;
  logic [4:0]    rem;
  logic [AW-1:0] exp_addr;

  logic          err_now, accepted, burst_done, wrap;
  logic [4:0]    nb;
  logic [AW-1:0] step, sum, span, nxt;

  assign err_now    = bus_resp == R_ERR;
  assign accepted   = bus_ready && bus_trans[1];
  assign burst_done = accepted && bus_trans == T_SEQ && in_bst && bst_fix && rem == 5'd1;

  assign nb   = beats_of(bus_burst);
  assign wrap = bus_burst != 3'd0 && !bus_burst[0];
  assign step = AW'(1) << bus_size;
  assign sum  = bus_addr + step;
  assign span = (AW'(nb) << bus_size) - AW'(1);
  assign nxt  = wrap ? ((bus_addr & ~span) | (sum & span)) : sum;

  logic c_hold, c_stall, c_err, c_resp, c_baddr, c_btype;

  assign c_hold  = !p_ready && (bus_addr != p_addr || bus_write != p_write ||
                                bus_size != p_size || bus_burst != p_burst);
  assign c_stall = !bus_ready && lcnt == LW'(MAXW - 1);
  assign c_err   = p_err1 && !(err_now && bus_ready);
  assign c_resp  = bus_resp[1];
  assign c_baddr = in_bst && bus_trans == T_SEQ && bus_addr != exp_addr;
  assign c_btype = in_bst && bst_fix && !bus_trans[0];

  assign any_violation = flag_hold | flag_stall | flag_err_seq |
                         flag_resp_code | flag_burst_addr | flag_burst_type;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_addr  <= '0;
      p_write <= 1'b0;
      p_size  <= '0;
      p_burst <= '0;
      p_ready <= 1'b1;
      p_err1  <= 1'b0;
      lcnt    <= '0;
    end else begin
      p_addr  <= bus_addr;
      p_write <= bus_write;
      p_size  <= bus_size;
      p_burst <= bus_burst;
      p_ready <= bus_ready;
      p_err1  <= err_now && !bus_ready;
      if (bus_ready)               lcnt <= '0;
      else if (lcnt != LW'(MAXW))  lcnt <= lcnt + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hold       <= 1'b0;
      flag_stall      <= 1'b0;
      flag_err_seq    <= 1'b0;
      flag_resp_code  <= 1'b0;
      flag_burst_addr <= 1'b0;
      flag_burst_type <= 1'b0;
    end else begin
      flag_hold       <= flag_hold       | c_hold;
      flag_stall      <= flag_stall      | c_stall;
      flag_err_seq    <= flag_err_seq    | c_err;
      flag_resp_code  <= flag_resp_code  | c_resp;
      flag_burst_addr <= flag_burst_addr | c_baddr;
      flag_burst_type <= flag_burst_type | c_btype;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_bst   <= 1'b0;
      bst_fix  <= 1'b0;
      rem      <= '0;
      exp_addr <= '0;
    end else if (accepted) begin
      if (bus_trans == T_NSEQ) begin
        in_bst   <= bus_burst != 3'd0;
        bst_fix  <= bus_burst > 3'd1;
        rem      <= nb - 5'd1;
        exp_addr <= nxt;
      end else if (in_bst) begin
        exp_addr <= nxt;
        if (bst_fix) begin
          rem <= rem - 5'd1;
          if (rem == 5'd1) in_bst <= 1'b0;
        end
      end
    end else if (bus_ready && bus_trans == T_IDLE) begin
      in_bst <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cov_wait  <= '0;
      cov_err   <= '0;
      cov_burst <= '0;
    end else begin
      if (!bus_ready)           cov_wait  <= cov_wait + CW'(1);
      if (err_now && bus_ready) cov_err   <= cov_err + CW'(1);
      if (burst_done)           cov_burst <= cov_burst + CW'(1);
    end
  end

endmodule

// File: rtl/ahbl_watch_chk.sv
module ahbl_watch_chk #(
  parameter int AW   = 32,
  parameter int MAXW = 16,
  parameter int CW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ready,
  input logic [1:0]    bus_resp,
  input logic          flag_hold,
  input logic          flag_stall,
  input logic          flag_err_seq,
  input logic          flag_resp_code,
  input logic          any_violation,
  input logic [CW-1:0] cov_wait
);

  localparam int LW = $clog2(MAXW + 1);

  logic          armed;
  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      low_run <= '0;
    end else begin
      armed <= 1'b1;
      if (bus_ready)                 low_run <= '0;
      else if (low_run != LW'(MAXW)) low_run <= low_run + LW'(1);
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(bus_ready) && bus_addr != $past(bus_addr)) |=> flag_hold);

  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_ready && low_run == LW'(MAXW - 1)) |=> flag_stall);

  p_err_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(bus_resp == 2'b01 && !bus_ready) &&
     !(bus_resp == 2'b01 && bus_ready)) |=> flag_err_seq);

  p_resp_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_resp[1] |=> flag_resp_code);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_violation |=> any_violation);

  p_wait_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> cov_wait == $past(cov_wait) + CW'(1));

endmodule

bind ahbl_watch ahbl_watch_chk #(.AW(AW), .MAXW(MAXW), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_ready      (bus_ready),
  .bus_resp       (bus_resp),
  .flag_hold      (flag_hold),
  .flag_stall     (flag_stall),
  .flag_err_seq   (flag_err_seq),
  .flag_resp_code (flag_resp_code),
  .any_violation  (any_violation),
  .cov_wait       (cov_wait)
);

// File: tb/ahbl_watch_tb.sv
`timescale 1ns/1ps
module ahbl_watch_tb;
  localparam int MAXW = 16;
  localparam logic [1:0] IDLE = 2'b00, BUSY = 2'b01, NSEQ = 2'b10, SEQ = 2'b11;
  localparam logic [1:0] OK = 2'b00, ERR = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  trans = IDLE;
  logic        wr = 1'b0;
  logic [2:0]  size = '0, burst = '0;
  logic        ready = 1'b1;
  logic [1:0]  resp = OK;
  logic f_hold, f_stall, f_err, f_resp, f_baddr, f_btype, anyv;
  logic [15:0] c_wait, c_err, c_burst;

  always #2.5 clk = ~clk;

  ahbl_watch #(.AW(32), .MAXW(MAXW), .CW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_trans(trans), .bus_write(wr),
    .bus_size(size), .bus_burst(burst), .bus_ready(ready), .bus_resp(resp),
    .flag_hold(f_hold), .flag_stall(f_stall), .flag_err_seq(f_err),
    .flag_resp_code(f_resp), .flag_burst_addr(f_baddr), .flag_burst_type(f_btype),
    .any_violation(anyv), .cov_wait(c_wait), .cov_err(c_err), .cov_burst(c_burst));

  int n_checks = 0, n_errors = 0;
  int exp_wait = 0, exp_err = 0, exp_burst = 0;
  bit finished = 0;

  // flag order: hold, stall, err_seq, resp_code, burst_addr, burst_type
  localparam logic [5:0] F_NONE = 6'b000000, F_HOLD = 6'b100000, F_STALL = 6'b010000,
                         F_ERR = 6'b001000, F_RESP = 6'b000100, F_BADDR = 6'b000010,
                         F_BTYPE = 6'b000001;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input string tag, input logic [5:0] exp);
    chk(tag, 32'({f_hold, f_stall, f_err, f_resp, f_baddr, f_btype}), 32'(exp));
    chk({tag, " R8 any_violation"}, 32'(anyv), 32'(|exp));
  endtask

  task automatic tick(input logic [31:0] a, input logic [1:0] t, input logic w,
                      input logic [2:0] s, input logic [2:0] b, input logic r,
                      input logic [1:0] p);
    addr = a; trans = t; wr = w; size = s; burst = b; ready = r; resp = p;
    if (!r) exp_wait++;
    if (p == ERR && r) exp_err++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    addr = '0; trans = IDLE; wr = 0; size = 0; burst = 0; ready = 1; resp = OK;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_wait = 0; exp_err = 0; exp_burst = 0;
  endtask

  function automatic int nbeats(input logic [2:0] k);
    case (k)
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      3'd6, 3'd7: return 16;
      default:    return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_next(input logic [31:0] a, input logic [2:0] s,
                                           input logic [2:0] k);
    int unsigned inc, blk, base;
    inc = 1 << s;
    if (k == 3'd2 || k == 3'd4 || k == 3'd6) begin
      blk  = nbeats(k) * inc;
      base = a - (a % blk);
      return base + ((a - base + inc) % blk);
    end
    return a + inc;
  endfunction

  task automatic beat(input logic [31:0] a, input logic [1:0] t, input logic w,
                      input logic [2:0] s, input logic [2:0] b);
    int w_n;
    w_n = int'($urandom % 4);
    for (int i = 0; i < w_n; i++) tick(a, t, w, s, b, 1'b0, OK);
    tick(a, t, w, s, b, 1'b1, OK);
  endtask

  task automatic op_single();
    logic [31:0] a; logic [2:0] s; logic w;
    s = 3'($urandom % 3); w = 1'($urandom);
    a = $urandom & 32'h0000_FFF0;
    beat(a, NSEQ, w, s, 3'd0);
    if ($urandom % 3 == 0) begin
      tick(a, IDLE, w, s, 3'd0, 1'b0, ERR);
      tick(a, IDLE, w, s, 3'd0, 1'b1, ERR);
    end
  endtask

  task automatic op_burst();
    logic [31:0] a; logic [2:0] s, k; logic w; int n;
    s = 3'($urandom % 3); w = 1'($urandom);
    k = 3'(1 + $urandom % 7);
    a = $urandom & 32'h0000_FFF0;
    n = (k == 3'd1) ? int'(1 + $urandom % 5) : nbeats(k);
    for (int i = 0; i < n; i++) begin
      if (i > 0 && $urandom % 5 == 0) tick(a, BUSY, w, s, k, 1'b1, OK);
      beat(a, (i == 0) ? NSEQ : SEQ, w, s, k);
      a = exp_next(a, s, k);
    end
    if (k != 3'd1) exp_burst++;
  endtask

  initial begin : main
    void'($urandom(32'h0000_5EED));
    @(negedge clk);
    do_reset();
    chk_flags("R7 reset flags", F_NONE);
    chk("R7 reset wait count", 32'(c_wait), 0);
    chk("R7 reset burst count", 32'(c_burst), 0);

    // legal random traffic
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 2 == 0) op_single(); else op_burst();
      if ($urandom % 4 == 0) tick(addr, IDLE, wr, size, burst, 1'b1, OK);
    end
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, OK);
    chk_flags("R1-R6 legal traffic flags", F_NONE);
    chk("R9 wait count", 32'(c_wait), 32'(exp_wait));
    chk("R10 error count", 32'(c_err), 32'(exp_err));
    chk("R11 burst count", 32'(c_burst), 32'(exp_burst));

    // R1: address change in a wait
    do_reset();
    tick(32'h40, NSEQ, 1'b0, 3'd2, 3'd0, 1'b0, OK);
    tick(32'h44, NSEQ, 1'b0, 3'd2, 3'd0, 1'b1, OK);
    chk_flags("R1 addr changed mid-wait", F_HOLD);
    repeat (5) tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, OK);
    chk_flags("R7 flag stays sticky", F_HOLD);
    do_reset();
    chk_flags("R7 reset clears flags", F_NONE);
    tick(32'h40, NSEQ, 1'b0, 3'd2, 3'd0, 1'b0, OK);
    tick(32'h40, NSEQ, 1'b0, 3'd1, 3'd0, 1'b1, OK);
    chk_flags("R1 size changed mid-wait", F_HOLD);
    do_reset();
    tick(32'h40, NSEQ, 1'b0, 3'd2, 3'd0, 1'b0, OK);
    tick(32'h40, NSEQ, 1'b1, 3'd2, 3'd0, 1'b1, OK);
    chk_flags("R1 write changed mid-wait", F_HOLD);

    // R2: stall bound
    do_reset();
    repeat (MAXW - 1) tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, OK);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, OK);
    chk_flags("R2 stall of MAXW-1", F_NONE);
    repeat (MAXW - 1) tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, OK);
    chk_flags("R2 stall just below bound", F_NONE);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, OK);
    chk_flags("R2 stall reaches MAXW", F_STALL);
    chk("R9 wait count after stalls", 32'(c_wait), 32'(2 * MAXW - 1));

    // R3: error sequence
    do_reset();
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, ERR);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, ERR);
    chk_flags("R3 two-cycle error", F_NONE);
    chk("R10 error count", 32'(c_err), 1);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, ERR);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, OK);
    chk_flags("R3 one-cycle error", F_ERR);
    do_reset();
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, ERR);
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b0, ERR);
    chk_flags("R3 error with ready still low", F_ERR);

    // R4: response code
    do_reset();
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, 2'b10);
    chk_flags("R4 code 2'b10", F_RESP);
    do_reset();
    tick(32'h0, IDLE, 1'b0, 3'd0, 3'd0, 1'b1, 2'b11);
    chk_flags("R4 code 2'b11", F_RESP);

    // R5: burst addresses
    do_reset();
    tick(32'h38, NSEQ, 1'b0, 3'd2, 3'd2, 1'b1, OK);
    tick(32'h3C, SEQ,  1'b0, 3'd2, 3'd2, 1'b1, OK);
    tick(32'h30, SEQ,  1'b0, 3'd2, 3'd2, 1'b1, OK);
    tick(32'h34, SEQ,  1'b0, 3'd2, 3'd2, 1'b1, OK);
    tick(32'h0,  IDLE, 1'b0, 3'd0, 3'd0, 1'b1, OK);
    chk_flags("R5 wrap4 crossing block edge", F_NONE);
    chk("R11 wrap4 completed", 32'(c_burst), 1);
    do_reset();
    tick(32'h100, NSEQ, 1'b0, 3'd2, 3'd3, 1'b1, OK);
    tick(32'h104, SEQ,  1'b0, 3'd2, 3'd3, 1'b1, OK);
    tick(32'h10C, SEQ,  1'b0, 3'd2, 3'd3, 1'b1, OK);
    chk_flags("R5 incr4 skipped address", F_BADDR);
    do_reset();
    tick(32'h1C, NSEQ, 1'b0, 3'd1, 3'd4, 1'b1, OK);
    tick(32'h1E, SEQ,  1'b0, 3'd1, 3'd4, 1'b1, OK);
    tick(32'h20, SEQ,  1'b0, 3'd1, 3'd4, 1'b1, OK);
    chk_flags("R5 wrap8 failed to wrap", F_BADDR);

    // R6: transfer types inside bursts
    do_reset();
    tick(32'h200, NSEQ, 1'b0, 3'd2, 3'd3, 1'b1, OK);
    tick(32'h204, SEQ,  1'b0, 3'd2, 3'd3, 1'b1, OK);
    tick(32'h208, IDLE, 1'b0, 3'd2, 3'd3, 1'b1, OK);
    chk_flags("R6 idle mid fixed burst", F_BTYPE);
    do_reset();
    tick(32'h400, NSEQ, 1'b0, 3'd2, 3'd5, 1'b1, OK);
    tick(32'h500, NSEQ, 1'b0, 3'd2, 3'd0, 1'b1, OK);
    chk_flags("R6 nonseq mid fixed burst", F_BTYPE);
    do_reset();
    tick(32'h300, NSEQ, 1'b0, 3'd2, 3'd1, 1'b1, OK);
    tick(32'h304, SEQ,  1'b0, 3'd2, 3'd1, 1'b1, OK);
    tick(32'h308, IDLE, 1'b0, 3'd2, 3'd1, 1'b1, OK);
    tick(32'h600, NSEQ, 1'b0, 3'd2, 3'd0, 1'b1, OK);
    chk_flags("R6 open burst ended by idle", F_NONE);
    chk("R11 open burst not counted", 32'(c_burst), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1-R11 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule